// File: doc/BRIEF.md
# Self-Clocked Converter Frame Receiver

This block sits on the host side of a serial link to a data converter that produces its own serial clock. Both the converter's clock line and its data line are brought into the host clock domain through multi-flop synchronizers. Rising edges of the converter clock are then found by comparing the synchronized clock with its value one cycle earlier.

The converter holds both lines high while it converts. It pulls both low when a result is ready, and then clocks out a fixed-length frame, most significant bit first. The receiver arms only after it has seen the high-high conversion phase followed by the low-low start condition. It then shifts in one bit on each rising edge and checks the status bit taken on the first edge. When the frame is complete, it registers a signed result and an over-range flag together and raises a one-cycle valid pulse.

A frame whose status bit is set is rejected with a one-cycle error pulse. If the clock stops in the middle of a frame, a timeout sends the receiver back to waiting for the next conversion. The host clock must run at least four times faster than the converter clock.

Top module: `adc_frame_rx`

## Requirements
- R1: During and after synchronous reset, `valid` and `frame_err` are low, `result` is 0 and `over_range` is 0.
- R2: A frame starts only after both synchronized inputs have been high together and have then both been low together. Clock pulses seen without a preceding high-high phase produce neither `valid` nor `frame_err`.
- R3: Each frame bit is sampled from the data line at a synchronized rising edge of the converter clock. The first edge gives frame bit 31 and the 32nd edge gives frame bit 0.
- R4: If frame bit 31 (status, sampled on the first edge) is 1, `frame_err` pulses for one cycle, no `valid` is produced, and the receiver waits for the next conversion phase.
- R5: `result` is signed 24-bit. `result[23]` is the inverse of frame bit 29 (sign bit, 1 means non-negative), and `result[22:0]` holds frame bits 27 down to 5, which are the upper 23 bits of the 24-bit code in bits 27..4.
- R6: `over_range` equals frame bit 28 of the accepted frame.
- R7: `valid` is high for exactly one system clock per accepted frame. `result` and `over_range` change only together with `valid` and hold their values otherwise.
- R8: If no rising clock edge arrives within `TIMEOUT_CLKS` system clocks during a frame, the partial frame is dropped without `valid`, and the next complete frame is received correctly.
- R9: After the 32nd edge, the receiver waits for a fresh high-high conversion phase before accepting another frame.
- R10: Frame bit 30 and frame bits 3 down to 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Converter-driven serial clock (asynchronous) |
| sdo_in | input | 1 | Converter serial data (asynchronous) |
| result | output | 24 | Signed conversion result |
| over_range | output | 1 | Extended-range flag of the last accepted frame |
| valid | output | 1 | One-cycle pulse when a new result is registered |
| frame_err | output | 1 | One-cycle pulse when a frame is rejected on its status bit |

## Verification
The bench builds the receiver with `TIMEOUT_CLKS` set to 64 and drives a converter clock with a half period of six system clocks. At that setting, a stall of 100 clocks in the middle of a frame crosses the timeout, while normal bit spacing stays well inside it, so the abort path and the recovery after it can be reached in a short run. The frame and result widths keep their default values, so the field positions tested are the ones the decoder is built for.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_CONV = 2'd0,
    ST_ARMED     = 2'd1,
    ST_SHIFT     = 2'd2
  } rx_state_t;
endpackage

// File: rtl/adc_rx_sync.sv
module adc_rx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= '0;
      else     pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/adc_rx_shifter.sv
module adc_rx_shifter
  import adc_rx_pkg::*;
#(
  parameter int FRAME_BITS   = 32,
  parameter int TIMEOUT_CLKS = 1024
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_s,
  input  logic                  sdo_s,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  frame_done,
  output logic                  status_err
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int WD_W  = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(TIMEOUT_CLKS - 1);

  rx_state_t         state;
  logic              sck_d;
  logic              rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WD_W-1:0]   wd_cnt;
  logic [FRAME_BITS-1:0] shreg;

  assign rise       = sck_s & ~sck_d;
  assign frame_word = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_WAIT_CONV;
      sck_d      <= 1'b0;
      bit_cnt    <= '0;
      wd_cnt     <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
      status_err <= 1'b0;
    end else begin
      sck_d      <= sck_s;
      frame_done <= 1'b0;
      status_err <= 1'b0;
      case (state)
        ST_WAIT_CONV: begin
          if (sck_s && sdo_s) state <= ST_ARMED;
        end
        ST_ARMED: begin
          if (!sck_s && !sdo_s) begin
            state   <= ST_SHIFT;
            bit_cnt <= '0;
            wd_cnt  <= '0;
          end
        end
        ST_SHIFT: begin
          if (rise) begin
            wd_cnt  <= '0;
            shreg   <= {shreg[FRAME_BITS-2:0], sdo_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == '0 && sdo_s) begin
              status_err <= 1'b1;
              state      <= ST_WAIT_CONV;
            end else if (bit_cnt == LAST_BIT) begin
              frame_done <= 1'b1;
              state      <= ST_WAIT_CONV;
            end
          end else if (wd_cnt == WD_LAST) begin
            state <= ST_WAIT_CONV;
          end else begin
            wd_cnt <= wd_cnt + 1'b1;
          end
        end
        default: state <= ST_WAIT_CONV;
      endcase
    end
  end

  // R3: the bit counter never runs past one frame
  assert_bitcnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (bit_cnt < CNT_W'(FRAME_BITS)));

  // R8: the timeout counter stays inside its window
  assert_wd_bound_R8: assert property (@(posedge clk) disable iff (rst)
    wd_cnt < WD_W'(TIMEOUT_CLKS));

  // R2: shifting is entered only from the armed state
  assert_start_from_armed_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && $past(state) != ST_SHIFT) |-> $past(state) == ST_ARMED);

  // R9: a completed frame leaves the receiver waiting for a conversion
  assert_done_returns_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ($past(state) == ST_SHIFT && state == ST_WAIT_CONV));

  // R4: a status rejection comes only from the first edge
  assert_err_first_edge_R4: assert property (@(posedge clk) disable iff (rst)
    status_err |-> ($past(bit_cnt) == '0 && $past(sdo_s)));
endmodule

// File: rtl/adc_rx_decode.sv
module adc_rx_decode #(
  parameter int FRAME_BITS = 32,
  parameter int RESULT_W   = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [FRAME_BITS-1:0]      frame_word,
  input  logic                       frame_done,
  input  logic                       status_err,
  output logic signed [RESULT_W-1:0] result,
  output logic                       over_range,
  output logic                       valid,
  output logic                       frame_err
);
  localparam int SIGN_POS = FRAME_BITS - 3;
  localparam int OVR_POS  = FRAME_BITS - 4;
  localparam int CODE_MSB = FRAME_BITS - 5;

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      over_range <= 1'b0;
      valid      <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      valid     <= frame_done;
      frame_err <= status_err;
      if (frame_done) begin
        result     <= {~frame_word[SIGN_POS], frame_word[CODE_MSB -: RESULT_W-1]};
        over_range <= frame_word[OVR_POS];
      end
    end
  end

  // R7: a new result is announced for one cycle only
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7: outputs hold between announcements
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(result) && $stable(over_range)));

  // R4: a rejected frame never also reports a result
  assert_err_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(valid && frame_err));
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
  parameter int FRAME_BITS   = 32,
  parameter int RESULT_W     = 24,
  parameter int SYNC_STAGES  = 2,
  parameter int TIMEOUT_CLKS = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_in,
  input  logic                sdo_in,
  output logic [RESULT_W-1:0] result,
  output logic                over_range,
  output logic                valid,
  output logic                frame_err
);
  logic [1:0]            sync_q;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  frame_done;
  logic                  status_err;

  adc_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_in, sdo_in}),
    .q   (sync_q)
  );

  adc_rx_shifter #(.FRAME_BITS(FRAME_BITS), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sck_s      (sync_q[1]),
    .sdo_s      (sync_q[0]),
    .frame_word (frame_word),
    .frame_done (frame_done),
    .status_err (status_err)
  );

  adc_rx_decode #(.FRAME_BITS(FRAME_BITS), .RESULT_W(RESULT_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .frame_word (frame_word),
    .frame_done (frame_done),
    .status_err (status_err),
    .result     (result),
    .over_range (over_range),
    .valid      (valid),
    .frame_err  (frame_err)
  );
endmodule

// File: tb/adc_frame_rx_test.sv
module adc_frame_rx_test;
  localparam int HALF = 6;
  localparam int CONV = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_in = 1'b0;
  logic sdo_in = 1'b0;
  logic [23:0] result;
  logic over_range, valid, frame_err;

  int checks = 0, fails = 0, cycles = 0;
  int vcnt = 0, ecnt = 0, multi = 0;
  logic prev_v = 1'b0, prev_e = 1'b0;
  logic [23:0] cap_res = '0;
  logic cap_ovr = 1'b0;

  always #4 clk = ~clk;

  adc_frame_rx #(.TIMEOUT_CLKS(64)) uut (
    .clk(clk), .rst(rst), .sck_in(sck_in), .sdo_in(sdo_in),
    .result(result), .over_range(over_range), .valid(valid), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (valid) begin
        vcnt++; cap_res = result; cap_ovr = over_range;
        if (prev_v) multi++;
      end
      if (frame_err) begin
        ecnt++;
        if (prev_e) multi++;
      end
      prev_v = valid; prev_e = frame_err;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_res(input logic [31:0] w);
    return {~w[29], w[27:5]};
  endfunction

  task automatic send(input logic [31:0] w, input int nedges);
    sck_in = 1'b1; sdo_in = 1'b1;
    repeat (CONV) @(negedge clk);
    sck_in = 1'b0; sdo_in = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 31; i >= 32 - nedges; i--) begin
      sdo_in = w[i];
      repeat (HALF) @(negedge clk);
      sck_in = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i > 32 - nedges) sck_in = 1'b0;
    end
    sck_in = 1'b1; sdo_in = 1'b1;
    repeat (CONV) @(negedge clk);
  endtask

  task automatic good_frame(input logic [31:0] w, input string tag);
    int v0, e0;
    v0 = vcnt; e0 = ecnt;
    send(w, 32);
    chk(vcnt == v0 + 1, {tag, " R3 one valid per frame"}, vcnt - v0, 1);
    chk(ecnt == e0, {tag, " R4 no error on good frame"}, ecnt - e0, 0);
    chk(cap_res == exp_res(w), {tag, " R5 result"}, cap_res, exp_res(w));
    chk(cap_ovr == w[28], {tag, " R6 over_range"}, cap_ovr, w[28]);
    chk(result == cap_res, {tag, " R7 result held"}, result, cap_res);
  endtask

  initial begin
    logic [31:0] w, w2;
    int v0, e0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(valid == 0 && frame_err == 0, "R1 pulses low in reset", {valid, frame_err}, 0);
    chk(result == 0 && over_range == 0, "R1 outputs zero in reset", result, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid == 0 && frame_err == 0, "R1 pulses low after reset", {valid, frame_err}, 0);
    chk(result == 0 && over_range == 0, "R1 outputs zero after reset", result, 0);

    // R2: clock pulses without a conversion phase
    for (int i = 0; i < 32; i++) begin
      repeat (HALF) @(negedge clk); sck_in = 1'b1;
      repeat (HALF) @(negedge clk); sck_in = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk(vcnt == 0 && ecnt == 0, "R2 no frame without conversion phase", vcnt + ecnt, 0);

    // directed corners
    good_frame(32'h2FFF_FFF0, "positive full scale");
    good_frame(32'h0000_0000, "negative zero code");
    good_frame(32'h3000_0000, "over-range positive");
    good_frame(32'h1FFF_FFFF, "negative over-range");

    // R10: ignored bits
    w  = 32'h2A5A_5A50;
    w2 = w | 32'h4000_000F;
    good_frame(w2, "R10 ignored bits set");
    chk(cap_res == exp_res(w) && cap_ovr == w[28], "R10 bits 30 and 3:0 ignored", cap_res, exp_res(w));

    // R4: status bit set
    v0 = vcnt; e0 = ecnt;
    send(32'h8000_0000, 1);
    chk(ecnt == e0 + 1, "R4 error pulse on status 1", ecnt - e0, 1);
    chk(vcnt == v0, "R4 no valid on rejected frame", vcnt - v0, 0);
    chk(result == exp_res(w2), "R4 R7 result held after rejection", result, exp_res(w2));
    good_frame(32'h2123_4560, "R9 frame after rejection");

    // R8: stall mid-frame
    v0 = vcnt;
    send(32'h2ABC_DEF0, 10);
    repeat (100) @(negedge clk);
    chk(vcnt == v0, "R8 no valid on stalled frame", vcnt - v0, 0);
    chk(result == exp_res(32'h2123_4560), "R8 R7 result held over stall", result, exp_res(32'h2123_4560));
    good_frame(32'h1357_9BD0, "R8 recovery frame");

    // random frames, R9 back-to-back
    for (int k = 0; k < 12; k++) begin
      w = $urandom;
      w[31] = 1'b0;
      good_frame(w, "R9 random back-to-back");
    end

    chk(multi == 0, "R7 pulses one cycle wide", multi, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule